// File: doc/BRIEF.md
# Boot Link Announce Transmitter

This block drives the serial transmit line of a boot loader while a host is still finding the link. From the moment reset is released it sends one fixed character, all ones by default, over and over with no gap. Because every data bit of that character is high, the only falling edge in each frame is the start bit. A host that picks its own baud rate can lock onto those edges.

The receive side raises a one-cycle strobe when it sees the first boot memory block begin. The transmitter then finishes the frame it is sending and leaves the line idle high. A status output stays high until that last stop bit ends. Bit timing comes from an external one-cycle baud enable: each bit lasts exactly one tick interval, and the line moves only in the cycle after a tick. Baud detection and receive parsing sit outside this block.

Top module: `uart_announce_tx`

## Requirements
- R1: While reset is asserted, and after release until the first baud tick, tx_line is high and announce_active is high.
- R2: The first baud tick after reset starts a frame by driving tx_line low, unless a stop strobe has already arrived.
- R3: A frame is 10 bit periods: one low start bit, then the 8 bits of the announce character (default 0xFF) least significant bit first, then one high stop bit, with no parity bit.
- R4: Every bit lasts exactly one baud tick interval. tx_line changes only in the cycle that follows a cycle with baud_tick high.
- R5: Frames run back to back. The tick that ends a stop bit begins the next start bit when no stop is pending.
- R6: A strobe on first_block_seen during a frame lets that frame finish in full before the line goes idle. The total number of frames sent after a strobe at tick t is (t+8)/10, rounded down.
- R7: After the final stop bit, announce_active goes low in the cycle after the tick that ends it. From then until reset, tx_line stays high and further strobes and ticks have no effect.
- R8: A strobe that arrives before the first baud tick means no frame is sent. announce_active falls after that first tick.
- R9: A strobe in the same cycle as the tick that ends a stop bit takes effect at that tick, so no further frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle enable that marks each bit boundary |
| first_block_seen | input | 1 | One-cycle strobe from the receiver: first boot block detected |
| tx_line | output | 1 | Serial transmit line, idle high |
| announce_active | output | 1 | High while announcing, low once the final frame has ended |

## Verification
The hardest case to produce is a stop strobe that lands in exactly the cycle of the tick that closes a stop bit. In that case the strobe must stop the next frame without cutting the current one short. The stimulus reaches it by choosing the strobe position as a tick number. It then issues the strobe either together with that tick or one cycle after the previous tick. Directed cases place that tick on a frame boundary, before any frame, and in the middle of a frame. Random cases vary the tick spacing and the strobe position.

// File: rtl/uart_ann_pkg.sv
package uart_ann_pkg;

   typedef enum logic [2:0] {
      ANN_WAIT  = 3'd0,
      ANN_START = 3'd1,
      ANN_DATA  = 3'd2,
      ANN_STOP  = 3'd3,
      ANN_IDLE  = 3'd4
   } ann_state_t;

endpackage

// File: rtl/ann_stop_latch.sv
module ann_stop_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   output logic stop_pending
);

   logic stop_lat;

   always_ff @(posedge clk) begin
      if (!rst_n) stop_lat <= 1'b0;
      else        stop_lat <= stop_lat | strobe;
   end

   // a strobe counts in the same cycle it arrives
   assign stop_pending = stop_lat | strobe;

   // R9
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(strobe) && $past(rst_n)) |-> stop_lat);

endmodule

// File: rtl/ann_bit_select.sv
module ann_bit_select #(
   parameter int          DATA_BITS = 8,
   parameter bit          LSB_FIRST = 1'b1,
   parameter logic [DATA_BITS-1:0] CHAR_VAL = '1,
   localparam int         IDX_W     = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1
) (
   input  logic [IDX_W-1:0] idx,
   output logic             bit_val
);

   generate
      if (LSB_FIRST) begin : g_lsb
         assign bit_val = CHAR_VAL[idx];
      end else begin : g_msb
         localparam logic [IDX_W-1:0] TOP = IDX_W'(DATA_BITS - 1);
         assign bit_val = CHAR_VAL[TOP - idx];
      end
   endgenerate

endmodule

// File: rtl/ann_bit_sequencer.sv
module ann_bit_sequencer
   import uart_ann_pkg::*;
#(
   parameter int DATA_BITS = 8,
   parameter int STOP_BITS = 1,
   localparam int IDX_W    = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1,
   localparam int STOP_W   = (STOP_BITS > 1) ? $clog2(STOP_BITS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             baud_tick,
   input  logic             stop_pending,
   input  logic             data_bit,
   output logic [IDX_W-1:0] idx,
   output logic             tx_line,
   output logic             active
);

   localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(DATA_BITS - 1);
   localparam logic [STOP_W-1:0] LAST_STOP = STOP_W'(STOP_BITS - 1);

   ann_state_t        state;
   logic [STOP_W-1:0] stop_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ANN_WAIT;
         idx      <= '0;
         stop_cnt <= '0;
      end else if (baud_tick) begin
         case (state)
            ANN_WAIT:  state <= stop_pending ? ANN_IDLE : ANN_START;
            ANN_START: begin
               state <= ANN_DATA;
               idx   <= '0;
            end
            ANN_DATA: begin
               if (idx == LAST_IDX) begin
                  state    <= ANN_STOP;
                  stop_cnt <= '0;
               end else begin
                  idx <= idx + IDX_W'(1);
               end
            end
            ANN_STOP: begin
               if (stop_cnt == LAST_STOP) state <= stop_pending ? ANN_IDLE : ANN_START;
               else                       stop_cnt <= stop_cnt + STOP_W'(1);
            end
            ANN_IDLE:  state <= ANN_IDLE;
            default:   state <= ANN_WAIT;
         endcase
      end
   end

   always_comb begin
      case (state)
         ANN_START: tx_line = 1'b0;
         ANN_DATA:  tx_line = data_bit;
         default:   tx_line = 1'b1;
      endcase
   end

   assign active = (state != ANN_IDLE);

   // R4
   line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(baud_tick) |-> $stable(tx_line));

   // R7
   idle_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ANN_IDLE) |=> (state == ANN_IDLE));

   // R3
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= LAST_IDX);

   // R6
   idle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ANN_IDLE) && ($past(state) != ANN_IDLE))
         |-> (($past(state) == ANN_STOP) || ($past(state) == ANN_WAIT)));

endmodule

// File: rtl/uart_announce_tx.sv
module uart_announce_tx #(
   parameter int                   DATA_BITS = 8,
   parameter int                   STOP_BITS = 1,
   parameter bit                   LSB_FIRST = 1'b1,
   parameter logic [DATA_BITS-1:0] CHAR_VAL  = '1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic baud_tick,
   input  logic first_block_seen,
   output logic tx_line,
   output logic announce_active
);

   localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

   generate
      if (DATA_BITS < 5 || DATA_BITS > 9) begin : g_bad_data
         $error("uart_announce_tx: DATA_BITS must be 5..9");
      end
      if (STOP_BITS < 1 || STOP_BITS > 2) begin : g_bad_stop
         $error("uart_announce_tx: STOP_BITS must be 1 or 2");
      end
   endgenerate

   logic             stop_pending;
   logic             data_bit;
   logic [IDX_W-1:0] bit_idx;

   ann_stop_latch u_latch (
      .clk          (clk),
      .rst_n        (rst_n),
      .strobe       (first_block_seen),
      .stop_pending (stop_pending)
   );

   ann_bit_select #(
      .DATA_BITS (DATA_BITS),
      .LSB_FIRST (LSB_FIRST),
      .CHAR_VAL  (CHAR_VAL)
   ) u_sel (
      .idx     (bit_idx),
      .bit_val (data_bit)
   );

   ann_bit_sequencer #(
      .DATA_BITS (DATA_BITS),
      .STOP_BITS (STOP_BITS)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .baud_tick    (baud_tick),
      .stop_pending (stop_pending),
      .data_bit     (data_bit),
      .idx          (bit_idx),
      .tx_line      (tx_line),
      .active       (announce_active)
   );

   // R1
   idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !announce_active |-> tx_line);

   // R7
   active_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(announce_active) |-> $past(baud_tick));

endmodule

// File: tb/tb_uart_announce_tx.sv
module tb_uart_announce_tx;

   localparam logic [7:0] ANN = 8'hFF;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n = 1'b0;
   logic baud_tick = 1'b0;
   logic first_block_seen = 1'b0;
   wire  tx_line;
   wire  announce_active;

   uart_announce_tx dut (
      .clk              (clk),
      .rst_n            (rst_n),
      .baud_tick        (baud_tick),
      .first_block_seen (first_block_seen),
      .tx_line          (tx_line),
      .announce_active  (announce_active)
   );

   int checks = 0;
   int fails  = 0;
   int total_cycles = 0;

   // reference model: frame position from the tick count
   int m_pos;
   bit m_idle, m_pend;

   always @(posedge clk) begin
      bit p;
      if (!rst_n) begin
         m_pos  = -1;
         m_idle = 1'b0;
         m_pend = 1'b0;
      end else begin
         p = m_pend | first_block_seen;
         if (baud_tick && !m_idle) begin
            if (m_pos == -1 || m_pos == 9) begin
               if (p) m_idle = 1'b1;
               else   m_pos  = 0;
            end else begin
               m_pos = m_pos + 1;
            end
         end
         m_pend = p;
      end
   end

   function automatic bit exp_line();
      if (m_idle || m_pos == -1) return 1'b1;
      if (m_pos == 0)            return 1'b0;
      if (m_pos <= 8)            return ANN[m_pos-1];
      return 1'b1;
   endfunction

   function automatic string req_tag();
      if (m_idle)      return "R7";
      if (m_pos == -1) return "R1";
      if (m_pos == 0)  return "R5/R2";
      if (m_pos <= 8)  return "R3/R4";
      return "R3";
   endfunction

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual=%0d expected=%0d at time %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      total_cycles++;
      if (total_cycles > 190000) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected<=190000 cycles", total_cycles);
         $display("  %0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   // t: tick number of the stop strobe; coincident: strobe in the same cycle as that tick
   task automatic run_case(int div, int t, bit coincident);
      int cnt = 0;
      int tick_n = 0;
      int starts = 0;
      bit prev = 1'b1;
      rst_n = 1'b0;
      baud_tick = 1'b0;
      first_block_seen = 1'b0;
      repeat (3) @(negedge clk);
      // R1 during reset
      check("R1 line in reset", tx_line, 1);
      check("R1 active in reset", announce_active, 1);
      rst_n = 1'b1;
      for (int cyc = 0; cyc < (t + 25) * div; cyc++) begin
         @(negedge clk);
         check(req_tag(), tx_line, exp_line());
         check(m_idle ? "R7 active" : "R1 active", announce_active, !m_idle);
         if (prev && !tx_line) starts++;
         prev = tx_line;
         cnt++;
         baud_tick = (cnt % div == 0);
         if (baud_tick) tick_n++;
         if (coincident || div == 1)
            first_block_seen = (baud_tick && tick_n == t);
         else
            first_block_seen = (cnt == (t - 1) * div + 1);
         // late strobe after going idle must be ignored (R7)
         if (baud_tick && tick_n == t + 12) first_block_seen = 1'b1;
      end
      @(negedge clk);
      // R6 / R8 / R9: whole frames sent before stopping
      check((t == 1) ? "R8 frame count" : ((t % 10 == 1) ? "R9 frame count" : "R6 frame count"),
            starts, (t + 8) / 10);
      check("R7 final active", announce_active, 0);
      check("R7 final line", tx_line, 1);
      baud_tick = 1'b0;
      first_block_seen = 1'b0;
   endtask

   initial begin
      int unsigned seed_v;
      seed_v = $urandom(32'h5eed_0042);
      // directed corners
      run_case(1, 1, 1'b1);   // R8 strobe with first tick
      run_case(4, 1, 1'b0);   // R8 strobe before first tick
      run_case(3, 11, 1'b1);  // R9 strobe on stop-ending tick
      run_case(3, 21, 1'b0);  // R9 just before boundary tick
      run_case(2, 12, 1'b1);  // R6 mid frame
      run_case(5, 35, 1'b0);  // R6 later frame
      run_case(1, 10, 1'b1);  // R4 tick every cycle, stop bit tick
      for (int i = 0; i < 30; i++) begin
         int d = 1 + int'($urandom_range(7));
         int tt = 1 + int'($urandom_range(59));
         bit co = 1'($urandom_range(1));
         run_case(d, tt, co);
      end
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule